// File: doc/BRIEF.md
# Mode-Reconfigurable Cache Index Decoder

This block turns a 48-bit access address and a requested line operation into the addressing signals for a 4-way cache with 64-byte lines. Each physical entry of the data array holds two line copies: an upper copy and a lower copy. The block drives the tag-array index, the tag value to store or compare, the physical entry index, and the upper and lower word-line selects. It also drives three copy strobes that move data between the two halves of an entry.

The block has two modes. In general mode the two halves of an entry hold two neighbouring sets, which gives 64KB of capacity. In versioned (transactional) mode the upper half holds the new value of a line and the lower half holds its old value, which gives 32KB. The stored tag always keeps the top index bit, so the tag is the same width in both modes.

A mode change is a handshake. When the requested mode differs from the active one, the block raises a flush request. It switches mode only after the flush has been reported done. All decode outputs are registered, with one cycle of latency.

Top module: `vcache_index_decode`

## Requirements
- R1: In both modes, `tag_val` equals address bits 47..13, which is 35 bits including the top index bit.
- R2: `tag_idx` equals address bits 13..6 in general mode. In versioned mode its top bit is 0 and its lower 7 bits equal address bits 12..6.
- R3: In general mode, read ops (codes 0, 2) and write ops (codes 1, 3) behave as follows:
  - `entry_idx` equals address bits 13..7.
  - Address bit 6 = 0 selects only `wl_up`, and address bit 6 = 1 selects only `wl_lo`. The upper/lower choice carried by the op code plays no part.
  - `wr_en` is high for codes 1 and 3.
- R4: In versioned mode, `entry_idx` equals address bits 12..6. The ops select word lines as follows:
  - Code 0 reads the upper (new) copy and code 2 reads the lower (old) copy.
  - Code 1 writes the upper copy and code 3 writes the lower copy, each with `wr_en` high.
- R5: In versioned mode, code 4 raises both `wl_up` and `wl_lo` with `wr_en`, so both copies are written together.
- R6: In versioned mode, code 5 raises only `copy_dn` (upper to lower), code 6 raises only `copy_up` (lower to upper), and code 7 raises only `copy_all` (every entry upper to lower). None of these raises a word line or `wr_en`.
- R7: In general mode, codes 4..7 are ignored: `out_vld` and every select and strobe stay low.
- R8: Outputs follow `acc_vld` by one clock. A cycle without an access gives `out_vld` low and all outputs zero.
- R9: When `mode_req` differs from `tm_active` and no flush is pending, `flush_req` rises on the next clock. `tm_active` does not change while no flush is pending.
- R10: When `flush_done` is sampled high while `flush_req` is high, `tm_active` takes the requested mode on that clock and `flush_req` falls. A `flush_done` with no pending flush has no effect.
- R11: After reset the block is in general mode, with `flush_req` and `out_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Requested mode, 1 = versioned |
| flush_done | input | 1 | Cache flush has completed |
| acc_vld | input | 1 | Access present this cycle |
| acc_addr | input | 48 | Access byte address |
| acc_op | input | 3 | Op code, 0..7 as in R3 to R6 |
| tm_active | output | 1 | Active mode, 1 = versioned |
| flush_req | output | 1 | Flush needed before the mode switch |
| out_vld | output | 1 | Decoded outputs are valid |
| tag_idx | output | 8 | Tag-array index |
| tag_val | output | 35 | Tag value |
| entry_idx | output | 7 | Physical entry index |
| wl_up | output | 1 | Upper-copy word line |
| wl_lo | output | 1 | Lower-copy word line |
| wr_en | output | 1 | Write through the selected word lines |
| copy_dn | output | 1 | Copy upper to lower in the entry |
| copy_up | output | 1 | Copy lower to upper in the entry |
| copy_all | output | 1 | Copy upper to lower in all entries |

## Verification
General-mode accesses use address bit 6 at both values under both read and write codes. This shows that the half choice comes from the address and not from the op. The same address patterns with bit 13 set are then replayed in versioned mode, which separates the forced-zero tag index from the retained tag bit. An all-ones address and a back-to-back stream of every op code in versioned mode check that neighbouring fields do not bleed into each other. The mode handshake is tried in three ways: a stray done pulse, an access issued while a flush is pending (it must still decode in the old mode), and a switch in each direction.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

    typedef enum logic [2:0] {
        OP_RD_NEW   = 3'd0,
        OP_WR_NEW   = 3'd1,
        OP_RD_OLD   = 3'd2,
        OP_WR_OLD   = 3'd3,
        OP_WR_PAIR  = 3'd4,
        OP_SAVE     = 3'd5,
        OP_RESTORE  = 3'd6,
        OP_SAVE_ALL = 3'd7
    } vop_e;

    typedef struct packed {
        logic wl_up;
        logic wl_lo;
        logic wr;
        logic cp_dn;
        logic cp_up;
        logic cp_all;
    } lsel_t;

endpackage

// File: rtl/vcd_index_map.sv
module vcd_index_map #(
    parameter int LA_W  = 42,
    parameter int IDX_W = 8,
    localparam int TAG_W = LA_W - IDX_W + 1,
    localparam int ENT_W = IDX_W - 1
) (
    input  logic [LA_W-1:0]  line_addr,
    input  logic             tm,
    output logic [IDX_W-1:0] tag_idx,
    output logic [TAG_W-1:0] tag_val,
    output logic [ENT_W-1:0] entry,
    output logic             half
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = line_addr[IDX_W-1:0];
        // top index bit stays in the tag so its width never depends on mode
        tag_val = line_addr[LA_W-1:IDX_W-1];
        half    = idx[0];
        if (tm) begin
            tag_idx = {1'b0, idx[IDX_W-2:0]};
            entry   = idx[IDX_W-2:0];
        end else begin
            tag_idx = idx;
            entry   = idx[IDX_W-1:1];
        end
    end
endmodule

// File: rtl/vcd_line_sel.sv
module vcd_line_sel
    import vcd_pkg::*;
(
    input  logic  tm,
    input  logic  half,
    input  vop_e  op,
    output logic  legal,
    output lsel_t sel
);
    always_comb begin
        sel   = '0;
        legal = 1'b1;
        if (!tm) begin
            case (op)
                OP_RD_NEW, OP_RD_OLD: begin
                    sel.wl_up = ~half;
                    sel.wl_lo = half;
                end
                OP_WR_NEW, OP_WR_OLD: begin
                    sel.wl_up = ~half;
                    sel.wl_lo = half;
                    sel.wr    = 1'b1;
                end
                default: legal = 1'b0;
            endcase
        end else begin
            case (op)
                OP_RD_NEW:   sel.wl_up = 1'b1;
                OP_WR_NEW:   begin sel.wl_up = 1'b1; sel.wr = 1'b1; end
                OP_RD_OLD:   sel.wl_lo = 1'b1;
                OP_WR_OLD:   begin sel.wl_lo = 1'b1; sel.wr = 1'b1; end
                OP_WR_PAIR:  begin sel.wl_up = 1'b1; sel.wl_lo = 1'b1; sel.wr = 1'b1; end
                OP_SAVE:     sel.cp_dn  = 1'b1;
                OP_RESTORE:  sel.cp_up  = 1'b1;
                OP_SAVE_ALL: sel.cp_all = 1'b1;
                default:     legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vcd_mode_ctl.sv
module vcd_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req,
    input  logic flush_done,
    output logic tm,
    output logic pending
);
    typedef struct packed {
        logic tm;
        logic pend;
        logic tgt;
    } mstate_t;

    mstate_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (!m_q.pend) begin
            if (mode_req != m_q.tm) begin
                m_d.pend = 1'b1;
                m_d.tgt  = mode_req;
            end
        end else if (flush_done) begin
            m_d.tm   = m_q.tgt;
            m_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign tm      = m_q.tm;
    assign pending = m_q.pend;
endmodule

// File: rtl/vcache_index_decode.sv
module vcache_index_decode
    import vcd_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int LINE_W = 6,
    parameter int IDX_W  = 8,
    localparam int LA_W  = ADDR_W - LINE_W,
    localparam int TAG_W = LA_W - IDX_W + 1,
    localparam int ENT_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req,
    input  logic              flush_done,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_op,
    output logic              tm_active,
    output logic              flush_req,
    output logic              out_vld,
    output logic [IDX_W-1:0]  tag_idx,
    output logic [TAG_W-1:0]  tag_val,
    output logic [ENT_W-1:0]  entry_idx,
    output logic              wl_up,
    output logic              wl_lo,
    output logic              wr_en,
    output logic              copy_dn,
    output logic              copy_up,
    output logic              copy_all
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] tidx;
        logic [TAG_W-1:0] tag;
        logic [ENT_W-1:0] ent;
        lsel_t            sel;
    } dec_t;

    dec_t r_d, r_q;

    logic             mode_tm;
    logic             mode_pend;
    logic [IDX_W-1:0] map_tidx;
    logic [TAG_W-1:0] map_tag;
    logic [ENT_W-1:0] map_ent;
    logic             map_half;
    logic             sel_legal;
    lsel_t            sel_v;
    logic             unused_ofs;

    assign unused_ofs = ^acc_addr[LINE_W-1:0];

    vcd_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req   (mode_req),
        .flush_done (flush_done),
        .tm         (mode_tm),
        .pending    (mode_pend)
    );

    vcd_index_map #(.LA_W(LA_W), .IDX_W(IDX_W)) u_map (
        .line_addr (acc_addr[ADDR_W-1:LINE_W]),
        .tm        (mode_tm),
        .tag_idx   (map_tidx),
        .tag_val   (map_tag),
        .entry     (map_ent),
        .half      (map_half)
    );

    vcd_line_sel u_sel (
        .tm    (mode_tm),
        .half  (map_half),
        .op    (vop_e'(acc_op)),
        .legal (sel_legal),
        .sel   (sel_v)
    );

    always_comb begin
        r_d = '0;
        if (acc_vld && sel_legal) begin
            r_d.vld  = 1'b1;
            r_d.tidx = map_tidx;
            r_d.tag  = map_tag;
            r_d.ent  = map_ent;
            r_d.sel  = sel_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tm_active = mode_tm;
    assign flush_req = mode_pend;
    assign out_vld   = r_q.vld;
    assign tag_idx   = r_q.tidx;
    assign tag_val   = r_q.tag;
    assign entry_idx = r_q.ent;
    assign wl_up     = r_q.sel.wl_up;
    assign wl_lo     = r_q.sel.wl_lo;
    assign wr_en     = r_q.sel.wr;
    assign copy_dn   = r_q.sel.cp_dn;
    assign copy_up   = r_q.sel.cp_up;
    assign copy_all  = r_q.sel.cp_all;
endmodule

// File: rtl/vcd_checker.sv
module vcd_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tm_active,
    input logic             flush_req,
    input logic             flush_done,
    input logic             out_vld,
    input logic [IDX_W-1:0] tag_idx,
    input logic             wl_up,
    input logic             wl_lo,
    input logic             wr_en,
    input logic             copy_dn,
    input logic             copy_up,
    input logic             copy_all
);
    AST_TM_TAG_IDX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && $past(tm_active) |-> !tag_idx[IDX_W-1]);                // R2

    AST_GP_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && !$past(tm_active) |-> $countones({wl_up, wl_lo}) == 1);  // R3

    AST_WRITE_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wl_up || wl_lo));                                        // R4

    AST_COPY_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_dn || copy_up || copy_all) |-> !(wl_up || wl_lo || wr_en));   // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !(wl_up || wl_lo || wr_en || copy_dn || copy_up || copy_all)); // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req |=> $stable(tm_active));                                 // R9

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && flush_done |=> !flush_req);                            // R10
endmodule

bind vcache_index_decode vcd_checker #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tm_active  (tm_active),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .out_vld    (out_vld),
    .tag_idx    (tag_idx),
    .wl_up      (wl_up),
    .wl_lo      (wl_lo),
    .wr_en      (wr_en),
    .copy_dn    (copy_dn),
    .copy_up    (copy_up),
    .copy_all   (copy_all)
);

// File: tb/vcache_index_decode_tb.sv
module vcache_index_decode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_req = 1'b0;
    logic        flush_done = 1'b0;
    logic        acc_vld = 1'b0;
    logic [47:0] acc_addr = '0;
    logic [2:0]  acc_op = '0;
    logic        tm_active, flush_req, out_vld;
    logic [7:0]  tag_idx;
    logic [34:0] tag_val;
    logic [6:0]  entry_idx;
    logic        wl_up, wl_lo, wr_en, copy_dn, copy_up, copy_all;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit tb_tm = 1'b0;

    typedef struct {
        logic [56:0] v;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    vcache_index_decode u_dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .flush_done(flush_done),
        .acc_vld(acc_vld), .acc_addr(acc_addr), .acc_op(acc_op),
        .tm_active(tm_active), .flush_req(flush_req), .out_vld(out_vld),
        .tag_idx(tag_idx), .tag_val(tag_val), .entry_idx(entry_idx),
        .wl_up(wl_up), .wl_lo(wl_lo), .wr_en(wr_en),
        .copy_dn(copy_dn), .copy_up(copy_up), .copy_all(copy_all)
    );

    // expected output vector: {vld, tag_idx, tag_val, entry, wl_up, wl_lo, wr, cp_dn, cp_up, cp_all}
    function automatic logic [56:0] model(input logic [47:0] a, input logic [2:0] op, input bit tm);
        logic [5:0] s;
        s = '0;
        if (!tm) begin
            if (op >= 3'd4) return '0;                                  // R7
            s[5] = ~a[6];
            s[4] = a[6];
            s[3] = (op == 3'd1) || (op == 3'd3);                        // R3
            return {1'b1, a[13:6], a[47:13], a[13:7], s};               // R1 R2 R3
        end
        case (op)
            3'd0: s = 6'b100000;
            3'd1: s = 6'b101000;
            3'd2: s = 6'b010000;
            3'd3: s = 6'b011000;                                        // R4
            3'd4: s = 6'b111000;                                        // R5
            3'd5: s = 6'b000100;
            3'd6: s = 6'b000010;
            default: s = 6'b000001;                                     // R6
        endcase
        return {1'b1, 1'b0, a[12:6], a[47:13], a[12:6], s};
    endfunction

    function automatic string req_of(input logic [2:0] op, input bit tm);
        if (!tm) return (op >= 3'd4) ? "R7" : "R1 R2 R3";
        if (op <= 3'd3) return "R1 R2 R4";
        if (op == 3'd4) return "R5";
        return "R6";
    endfunction

    task automatic acc(input logic [47:0] a, input logic [2:0] op);
        item_t it;
        @(negedge clk);
        acc_vld  = 1'b1;
        acc_addr = a;
        acc_op   = op;
        it.v   = model(a, op, tb_tm);
        it.req = req_of(op, tb_tm);
        sb_q.push_back(it);
    endtask

    task automatic idle();
        item_t it;
        @(negedge clk);
        acc_vld = 1'b0;
        acc_addr = 48'h5A5A_5A5A_5A5A;
        acc_op = 3'd1;
        it.v = '0;
        it.req = "R8";
        sb_q.push_back(it);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    // monitor: compares one queued expectation per clock
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [56:0] act;
                it  = sb_q.pop_front();
                act = {out_vld, tag_idx, tag_val, entry_idx, wl_up, wl_lo, wr_en, copy_dn, copy_up, copy_all};
                checks++;
                if (act !== it.v) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.v);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R11 out_vld", out_vld, 1'b0);
        chk("R11 flush_req", flush_req, 1'b0);
        chk("R11 tm_active", tm_active, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // general mode
        acc(48'h0000_0000_0000, 3'd0);
        acc(48'h0000_0000_0040, 3'd1);
        acc(48'h1234_5678_9A80, 3'd2);
        acc(48'hABCD_EF01_23C0, 3'd3);
        acc(48'hFFFF_FFFF_FFFF, 3'd0);
        acc(48'h0000_0000_2000, 3'd1);
        for (int k = 4; k < 8; k++) acc(48'h0000_0000_3FC0, 3'(k));
        idle();
        acc(48'h7777_0000_3FFF, 3'd3);
        idle();
        idle();

        // stray done pulse
        @(negedge clk);
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
        after_edge();
        chk("R10 stray done tm", tm_active, 1'b0);
        chk("R10 stray done flush", flush_req, 1'b0);

        // switch to versioned mode
        @(negedge clk);
        mode_req = 1'b1;
        after_edge();
        chk("R9 flush raised", flush_req, 1'b1);
        chk("R9 mode held", tm_active, 1'b0);
        acc(48'h0000_0000_2040, 3'd4);
        acc(48'h0000_0000_2040, 3'd1);
        idle();
        after_edge();
        chk("R9 still held", tm_active, 1'b0);
        @(negedge clk);
        flush_done = 1'b1;
        after_edge();
        chk("R10 mode switched", tm_active, 1'b1);
        chk("R10 flush dropped", flush_req, 1'b0);
        tb_tm = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;

        // versioned mode
        for (int k = 0; k < 8; k++) acc(48'h0000_0000_2040 + 48'(k) * 48'h1_2340, 3'(k));
        acc(48'hFFFF_FFFF_FFFF, 3'd4);
        acc(48'h8000_0000_3FC0, 3'd3);
        for (int k = 0; k < 16; k++) acc({8'hC3, 24'(k * 37), 16'(k * 16'h0A4C)}, 3'(k % 8));
        idle();

        // back to general mode
        @(negedge clk);
        mode_req = 1'b0;
        after_edge();
        chk("R9 flush raised back", flush_req, 1'b1);
        chk("R9 mode held back", tm_active, 1'b1);
        acc(48'h0000_0000_2040, 3'd2);
        idle();
        @(negedge clk);
        flush_done = 1'b1;
        after_edge();
        chk("R10 mode back", tm_active, 1'b0);
        chk("R10 flush dropped back", flush_req, 1'b0);
        tb_tm = 1'b0;
        @(negedge clk);
        flush_done = 1'b0;
        acc(48'h0000_0000_2040, 3'd5);
        acc(48'h0000_0000_2040, 3'd2);
        idle();

        repeat (4) @(posedge clk);
        #2;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule